// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Almost-Empty and Almost-Full Flags

This block is a first-in first-out buffer whose writer and reader run on unrelated clocks. Each word is 9 bits wide and the depth is a power of two set by a parameter. Apart from plain empty and full indications, the buffer drives two active-low warning flags. The almost-empty warning is in the reader's domain. The almost-full warning is in the writer's domain. Each warning compares the number of unread words against an offset that can be changed at run time.

The offsets arrive on two input buses from a separate offset register block. That block loads 7 into both offsets at reset, and software may change them later. The write pointer and the read pointer each cross into the other clock domain as a Gray code through a two-flop synchroniser. After the crossing, each side works out the fill level in binary. The flags of a domain are registered once, at the same edge that moves that domain's own pointer.

Top module: `pflag_fifo`

## Requirements
- R1: While `rstN` is low, `emptyFlag`=1, `fullFlag`=0, `almostEmptyN`=0, `almostFullN`=1 and `rdData`=0.
- R2: Words leave `rdData` in the order they were written. `rdData` updates at the read-clock edge that accepts a read (`rdEn`=1 while `emptyFlag`=0).
- R3: A write presented while `fullFlag`=1 is dropped: nothing is stored and the write address does not move.
- R4: A read presented while `emptyFlag`=1 is dropped: `rdData` holds its value and the read address does not move.
- R5: Once both domains have settled, `emptyFlag`=1 exactly when 0 words are unread, and `fullFlag`=1 exactly when DEPTH words are unread.
- R6: With n = `emptyOffset`, once settled, `almostEmptyN`=0 when the unread count is at most n, and 1 when it is n+1 or more.
- R7: With m = `fullOffset`, once settled, `almostFullN`=0 when the unread count is at least DEPTH-m, and 1 when the free space is greater than m.
- R8: A flag reacts to its own domain's pointer at the same edge that moves it. After an accepted write, `fullFlag` and `almostFullN` show the new count at that write edge. After an accepted read, `emptyFlag` and `almostEmptyN` do the same at that read edge.
- R9: A pointer move in one domain reaches the other domain's flags within five cycles of the observing clock, through a Gray-coded two-flop crossing.
- R10: A change to `emptyOffset` or `fullOffset` takes effect at the next edge of the flag's own clock, with no data moving.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rstN | input | 1 | Asynchronous active-low reset for both domains |
| wrClk | input | 1 | Write clock |
| wrEn | input | 1 | Write request |
| wrData | input | DATA_W | Word to store |
| fullOffset | input | ADDR_W | Almost-full offset m |
| rdClk | input | 1 | Read clock |
| rdEn | input | 1 | Read request |
| emptyOffset | input | ADDR_W | Almost-empty offset n |
| rdData | output | DATA_W | Registered output word |
| emptyFlag | output | 1 | No unread words (read domain) |
| fullFlag | output | 1 | No free locations (write domain) |
| almostEmptyN | output | 1 | Active-low almost-empty warning (read domain) |
| almostFullN | output | 1 | Active-low almost-full warning (write domain) |

## Verification
The hardest case to reach is a flag that depends on the other domain's pointer, together with the exact threshold edge for every offset pair. The pointer arrives late, so a naive sample right after an operation would catch a stale flag.

The bench therefore sweeps a grid of (n, m) pairs. For each pair it fills the buffer one word at a time to full, then drains it to empty. After each operation it first checks the flags of the acting domain at once. It then waits for both domains to settle and checks every flag against the arithmetically computed count. The sweep also drives writes into a full buffer and reads from an empty one, and changes the offsets while the fill level stays fixed.

// File: rtl/pflag_fifo_pkg.sv
package pflag_fifo_pkg;
  // Strobes from control to datapath: one per clock domain.
  typedef struct packed {
    logic wrAccept;
    logic rdAccept;
  } memStrobe_t;
endpackage

// File: rtl/pflag_sync2.sv
module pflag_sync2 #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/pflag_ctrl.sv
module pflag_ctrl
  import pflag_fifo_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              rstN,
  input  logic              wrClk,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] fullOffset,
  input  logic              rdClk,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] emptyOffset,
  output memStrobe_t        strobe,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [ADDR_W-1:0] rdAddr,
  output logic              emptyFlag,
  output logic              fullFlag,
  output logic              almostEmptyN,
  output logic              almostFullN
);
  localparam int PTR_W = ADDR_W + 1;
  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [PTR_W-1:0] DEPTH_P = PTR_W'(DEPTH);

  function automatic logic [PTR_W-1:0] grayToBin(input logic [PTR_W-1:0] g);
    logic [PTR_W-1:0] b;
    for (int i = 0; i < PTR_W; i++) b[i] = ^(g >> i);
    return b;
  endfunction

  logic [PTR_W-1:0] wrBin, wrGray, wrBinNext, wrCountNext, rdBinSync, rdGraySync;
  logic [PTR_W-1:0] rdBin, rdGray, rdBinNext, rdCountNext, wrBinSync, wrGraySync;
  logic [PTR_W-1:0] pafLimit;
  logic             wrAccept, rdAccept;

  // Write domain
  always_comb begin
    wrAccept    = wrEn & ~fullFlag;
    wrBinNext   = wrBin + PTR_W'(wrAccept);
    rdBinSync   = grayToBin(rdGraySync);
    wrCountNext = wrBinNext - rdBinSync;
    pafLimit    = DEPTH_P - {1'b0, fullOffset};
  end

  always_ff @(posedge wrClk or negedge rstN) begin
    if (!rstN) begin
      wrBin       <= '0;
      wrGray      <= '0;
      fullFlag    <= 1'b0;
      almostFullN <= 1'b1;
    end else begin
      wrBin       <= wrBinNext;
      wrGray      <= wrBinNext ^ (wrBinNext >> 1);
      fullFlag    <= (wrCountNext == DEPTH_P);
      almostFullN <= (wrCountNext < pafLimit);
    end
  end

  // Read domain
  always_comb begin
    rdAccept    = rdEn & ~emptyFlag;
    rdBinNext   = rdBin + PTR_W'(rdAccept);
    wrBinSync   = grayToBin(wrGraySync);
    rdCountNext = wrBinSync - rdBinNext;
  end

  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN) begin
      rdBin        <= '0;
      rdGray       <= '0;
      emptyFlag    <= 1'b1;
      almostEmptyN <= 1'b0;
    end else begin
      rdBin        <= rdBinNext;
      rdGray       <= rdBinNext ^ (rdBinNext >> 1);
      emptyFlag    <= (rdCountNext == '0);
      almostEmptyN <= (rdCountNext > {1'b0, emptyOffset});
    end
  end

  // Cross-domain pointer transfer
  pflag_sync2 #(.W(PTR_W)) rdToWr_i (
    .clk(wrClk), .rstN(rstN), .d(rdGray), .q(rdGraySync)
  );
  pflag_sync2 #(.W(PTR_W)) wrToRd_i (
    .clk(rdClk), .rstN(rstN), .d(wrGray), .q(wrGraySync)
  );

  assign strobe.wrAccept = wrAccept;
  assign strobe.rdAccept = rdAccept;
  assign wrAddr = wrBin[ADDR_W-1:0];
  assign rdAddr = rdBin[ADDR_W-1:0];
endmodule

// File: rtl/pflag_store.sv
module pflag_store
  import pflag_fifo_pkg::*;
#(
  parameter int DATA_W = 9,
  parameter int ADDR_W = 4
) (
  input  logic              rstN,
  input  logic              wrClk,
  input  logic              rdClk,
  input  memStrobe_t        strobe,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge wrClk) begin
    if (strobe.wrAccept) mem[wrAddr] <= wrData;
  end

  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN)                rdData <= '0;
    else if (strobe.rdAccept) rdData <= mem[rdAddr];
  end
endmodule

// File: rtl/pflag_fifo.sv
module pflag_fifo
  import pflag_fifo_pkg::*;
#(
  parameter int DATA_W = 9,
  parameter int ADDR_W = 4
) (
  input  logic              rstN,
  input  logic              wrClk,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] fullOffset,
  input  logic              rdClk,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] emptyOffset,
  output logic [DATA_W-1:0] rdData,
  output logic              emptyFlag,
  output logic              fullFlag,
  output logic              almostEmptyN,
  output logic              almostFullN
);
  memStrobe_t        strobe;
  logic [ADDR_W-1:0] wrAddr, rdAddr;

  pflag_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .rstN(rstN), .wrClk(wrClk), .wrEn(wrEn), .fullOffset(fullOffset),
    .rdClk(rdClk), .rdEn(rdEn), .emptyOffset(emptyOffset),
    .strobe(strobe), .wrAddr(wrAddr), .rdAddr(rdAddr),
    .emptyFlag(emptyFlag), .fullFlag(fullFlag),
    .almostEmptyN(almostEmptyN), .almostFullN(almostFullN)
  );

  pflag_store #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) store_i (
    .rstN(rstN), .wrClk(wrClk), .rdClk(rdClk), .strobe(strobe),
    .wrAddr(wrAddr), .rdAddr(rdAddr), .wrData(wrData), .rdData(rdData)
  );
endmodule

// File: rtl/pflag_fifo_chk.sv
module pflag_fifo_chk #(
  parameter int DATA_W = 9,
  parameter int ADDR_W = 4
) (
  input logic              rstN,
  input logic              wrClk,
  input logic              rdClk,
  input logic              wrEn,
  input logic              rdEn,
  input logic [ADDR_W-1:0] wrAddr,
  input logic [ADDR_W-1:0] rdAddr,
  input logic [DATA_W-1:0] rdData,
  input logic              emptyFlag,
  input logic              fullFlag,
  input logic              almostEmptyN,
  input logic              almostFullN
);
  p_full_write_hold_r3: assert property (@(posedge wrClk) disable iff (!rstN)
    (fullFlag && wrEn) |=> $stable(wrAddr));

  p_empty_read_hold_r4: assert property (@(posedge rdClk) disable iff (!rstN)
    (emptyFlag && rdEn) |=> ($stable(rdAddr) && $stable(rdData)));

  p_wr_advance_r2: assert property (@(posedge wrClk) disable iff (!rstN)
    (wrEn && !fullFlag) |=> (wrAddr == ADDR_W'($past(wrAddr) + 1'b1)));

  p_rd_advance_r2: assert property (@(posedge rdClk) disable iff (!rstN)
    (rdEn && !emptyFlag) |=> (rdAddr == ADDR_W'($past(rdAddr) + 1'b1)));

  p_full_in_paf_r7: assert property (@(posedge wrClk) disable iff (!rstN)
    fullFlag |-> !almostFullN);

  p_empty_in_pae_r6: assert property (@(posedge rdClk) disable iff (!rstN)
    emptyFlag |-> !almostEmptyN);
endmodule

bind pflag_fifo pflag_fifo_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) chk_i (
  .rstN(rstN), .wrClk(wrClk), .rdClk(rdClk), .wrEn(wrEn), .rdEn(rdEn),
  .wrAddr(wrAddr), .rdAddr(rdAddr), .rdData(rdData),
  .emptyFlag(emptyFlag), .fullFlag(fullFlag),
  .almostEmptyN(almostEmptyN), .almostFullN(almostFullN)
);

// File: tb/pflag_fifo_tb_top.sv
module pflag_fifo_tb_top;
  localparam int DATA_W = 9;
  localparam int ADDR_W = 4;
  localparam int DEPTH  = 1 << ADDR_W;

  logic              rstN, wrClk, rdClk, wrEn, rdEn;
  logic [DATA_W-1:0] wrData, rdData;
  logic [ADDR_W-1:0] fullOffset, emptyOffset;
  logic              emptyFlag, fullFlag, almostEmptyN, almostFullN;

  int nChecks = 0;
  int nFails  = 0;
  int cnt     = 0;
  bit done    = 0;
  logic [DATA_W-1:0] nextWr = 9'h011;
  logic [DATA_W-1:0] nextRd = 9'h011;
  logic [DATA_W-1:0] lastRd = '0;

  pflag_fifo #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) dut_i (
    .rstN(rstN), .wrClk(wrClk), .wrEn(wrEn), .wrData(wrData),
    .fullOffset(fullOffset), .rdClk(rdClk), .rdEn(rdEn),
    .emptyOffset(emptyOffset), .rdData(rdData), .emptyFlag(emptyFlag),
    .fullFlag(fullFlag), .almostEmptyN(almostEmptyN), .almostFullN(almostFullN)
  );

  initial wrClk = 0;
  always #2.5 wrClk = ~wrClk;
  initial rdClk = 0;
  always #4 rdClk = ~rdClk;

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h (count=%0d)", req, act, exp, cnt);
    end
  endtask

  task automatic settle();
    repeat (5) @(negedge wrClk);
    repeat (5) @(negedge rdClk);
  endtask

  task automatic checkAll(input string tag);
    check({tag, " R5 empty"}, emptyFlag, cnt == 0);
    check({tag, " R5 full"}, fullFlag, cnt == DEPTH);
    check({tag, " R6 almostEmptyN"}, almostEmptyN, cnt > int'(emptyOffset));
    check({tag, " R7 almostFullN"}, almostFullN, cnt < DEPTH - int'(fullOffset));
  endtask

  task automatic doWrite(input logic [DATA_W-1:0] val);
    @(negedge wrClk);
    wrEn = 1; wrData = val;
    @(negedge wrClk);
    wrEn = 0;
  endtask

  task automatic doRead();
    @(negedge rdClk);
    rdEn = 1;
    @(negedge rdClk);
    rdEn = 0;
  endtask

  task automatic pushOne();
    doWrite(nextWr);
    nextWr = nextWr + 9'd37;
    cnt++;
    // R8: write-domain flags reflect the write at its own edge
    check("R8 full after write", fullFlag, cnt == DEPTH);
    check("R8 almostFullN after write", almostFullN, cnt < DEPTH - int'(fullOffset));
    settle();
    checkAll("R9 after write");
  endtask

  task automatic popOne();
    doRead();
    cnt--;
    check("R2 read order", rdData, nextRd);
    lastRd = rdData;
    nextRd = nextRd + 9'd37;
    // R8: read-domain flags reflect the read at its own edge
    check("R8 empty after read", emptyFlag, cnt == 0);
    check("R8 almostEmptyN after read", almostEmptyN, cnt > int'(emptyOffset));
    settle();
    checkAll("R9 after read");
  endtask

  initial begin
    repeat (200000) @(posedge wrClk);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    rstN = 0; wrEn = 0; rdEn = 0; wrData = '0;
    fullOffset = 4'd7; emptyOffset = 4'd7;
    repeat (4) @(negedge wrClk);
    check("R1 empty at reset", emptyFlag, 1);
    check("R1 full at reset", fullFlag, 0);
    check("R1 almostEmptyN at reset", almostEmptyN, 0);
    check("R1 almostFullN at reset", almostFullN, 1);
    check("R1 rdData at reset", rdData, 0);
    @(negedge wrClk);
    rstN = 1;
    settle();

    // R4: read on an empty buffer
    doRead();
    check("R4 rdData held on empty read", rdData, 0);
    settle();
    checkAll("R4 empty read");

    for (int ni = 0; ni < 4; ni++) begin
      for (int mi = 0; mi < 4; mi++) begin
        emptyOffset = (ni == 0) ? 4'd0 : (ni == 1) ? 4'd3 : (ni == 2) ? 4'd7 : 4'd15;
        fullOffset  = (mi == 0) ? 4'd0 : (mi == 1) ? 4'd5 : (mi == 2) ? 4'd7 : 4'd15;
        settle();
        checkAll("R6 R7 start");
        for (int k = 0; k < DEPTH; k++) pushOne();
        // R3: write into a full buffer is dropped
        doWrite(9'h1AA);
        settle();
        check("R3 full holds after dropped write", fullFlag, 1);
        for (int k = 0; k < DEPTH; k++) popOne();
        // R4: read on empty keeps the last word
        doRead();
        check("R4 rdData held on empty read", rdData, lastRd);
        settle();
        checkAll("R4 after empty read");
      end
    end

    // R10: offsets change at a fixed fill level of 5
    emptyOffset = 4'd7; fullOffset = 4'd7;
    settle();
    for (int k = 0; k < 5; k++) pushOne();
    emptyOffset = 4'd4;
    repeat (2) @(negedge rdClk);
    check("R10 almostEmptyN n=4 count=5", almostEmptyN, 1);
    emptyOffset = 4'd5;
    repeat (2) @(negedge rdClk);
    check("R10 almostEmptyN n=5 count=5", almostEmptyN, 0);
    fullOffset = 4'd11;
    repeat (2) @(negedge wrClk);
    check("R10 almostFullN m=11 count=5", almostFullN, 0);
    fullOffset = 4'd10;
    repeat (2) @(negedge wrClk);
    check("R10 almostFullN m=10 count=5", almostFullN, 1);
    for (int k = 0; k < 5; k++) popOne();

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFails);
    $finish;
  end
endmodule